// File: doc/BRIEF.md
# Core Wrapper Boundary Register Chain

This block places one test cell on every unidirectional functional terminal of an embedded core. Each input cell sits between a chip-side input and the matching core input. Each output cell sits between a core output and the matching chip-side output. Every cell has two storage stages. The first is a dedicated shift stage that never carries functional data. The second is an update stage, and only the update stage can drive a functional path.

A test controller reaches the chain through one serial input and one serial output. Four controls set what the chain does on each clock: a select line, which marks the chain as the active data register, and capture, shift and update enables. A registered mode chooses one of three settings. In normal mode the cells are transparent. In inward-facing mode the chain exercises the core. In outward-facing mode the chain exercises the logic around the core.

Top module: `core_bscan_chain`

## Requirements
- R1: The serial path runs from `tdi_i` through the input cells, index 0 upward, and then through the output cells, index 0 upward, to `tdo_o`. `tdo_o` shows the shift stage of the last output cell. Each rising edge with `sel_i` and `shift_i` high and `capture_i` low moves the data by exactly one cell.
- R2: In inward-facing mode (mode code 01), `core_in_o` shows the update stages of the input cells, and `chip_out_o` follows `core_out_i`.
- R3: In outward-facing mode (mode code 10), `chip_out_o` shows the update stages of the output cells, and `core_in_o` follows `chip_in_i`.
- R4: In normal mode (mode code 00, and the spare code 11), `core_in_o` follows `chip_in_i` and `chip_out_o` follows `core_out_i`.
- R5: On a rising edge with `sel_i` and `capture_i` high, every shift stage loads its cell's functional input. For input cells that input is the chip-side input; for output cells it is the core output. When capture and shift are both asserted, capture wins.
- R6: On a falling edge with `sel_i` and `update_i` high, every update stage loads its shift stage in parallel.
- R7: An update stage holds its value on every falling edge without an update. Shifting therefore leaves the functional outputs unchanged while the data in the shift stages moves.
- R8: While `sel_i` is low, capture, shift and update have no effect on any stage.
- R9: The reset is synchronous and active-low. While `rst_n` is low, the shift stages clear on rising edges and the update stages clear on falling edges, all to zero. The mode returns to normal.
- R10: `mode_i` is registered on each rising edge. A new mode steers the functional outputs only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 00 normal, 01 inward-facing, 10 outward-facing, 11 normal |
| sel_i | input | 1 | Chain is the selected data register |
| capture_i | input | 1 | Capture enable |
| shift_i | input | 1 | Shift enable |
| update_i | input | 1 | Update enable, sampled on the falling edge |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out |
| chip_in_i | input | N_IN | Chip-side functional inputs |
| core_in_o | output | N_IN | Drives the core inputs |
| core_out_i | input | N_OUT | Core functional outputs |
| chip_out_o | output | N_OUT | Chip-side functional outputs |

## Verification
The assertions assume that every control and data input holds steady through both edges of a clock cycle. This matters because update is sampled on the falling edge and capture and shift on the rising edge, and both must see the same request. The bench changes every input one nanosecond after a rising edge and compares the outputs one nanosecond after the falling edge, so each edge sees settled values. Reset is held low across several full cycles. This lets the stages clocked on the rising edge and those clocked on the falling edge both clear before any assertion is evaluated.

// File: rtl/bscan_pkg.sv
// Package: shared mode encoding for the boundary chain.
// Assumes: a two-bit mode field; the spare code behaves like normal mode.
package bscan_pkg;
    typedef enum logic [1:0] {
        WM_NORMAL  = 2'b00,
        WM_INWARD  = 2'b01,
        WM_OUTWARD = 2'b10,
        WM_SPARE   = 2'b11
    } wrap_mode_e;
endpackage

// File: rtl/bscan_mode_reg.sv
// Module: registers the requested wrapper mode and decodes which cell group
// drives test data. Assumes mode_i is stable around the rising clock edge.
module bscan_mode_reg
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output logic       drive_in_cells_o,
    output logic       drive_out_cells_o
);
    wrap_mode_e mode_q;

    // Hold the active mode; reset returns the wrapper to normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= WM_NORMAL;
        else        mode_q <= wrap_mode_e'(mode_i);
    end

    // Decode which side of the core is under test control.
    always_comb begin
        drive_in_cells_o  = (mode_q == WM_INWARD);
        drive_out_cells_o = (mode_q == WM_OUTWARD);
    end

    // R9: after a reset cycle the mode is normal
    a_r9_mode_normal: assert property (@(posedge clk)
        !rst_n |=> (mode_q == WM_NORMAL));
endmodule

// File: rtl/bscan_cell.sv
// Module: one boundary cell with a dedicated shift stage and an update stage.
// The shift stage acts on the rising edge and the update stage on the falling
// edge. Assumes the controls are stable over a whole clock cycle.
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic drive_test_i,
    input  logic func_i,
    input  logic scan_i,
    output logic func_o,
    output logic scan_o
);
    logic sh_q;
    logic upd_q;

    // Shift stage: capture has priority over shift; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sh_q <= 1'b0;
        else if (sel_i && capture_i) sh_q <= func_i;
        else if (sel_i && shift_i)   sh_q <= scan_i;
    end

    // Update stage: parallel load on the falling edge, off the shift edge.
    always_ff @(negedge clk) begin
        if (!rst_n)                 upd_q <= 1'b0;
        else if (sel_i && update_i) upd_q <= sh_q;
    end

    // Functional path: the update stage replaces the functional value in test.
    always_comb begin
        func_o = drive_test_i ? upd_q : func_i;
        scan_o = sh_q;
    end

    // R5: capture loads the functional input, even with shift asserted
    a_r5_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && capture_i) |=> (sh_q == $past(func_i)));

    // R1: a pure shift moves the upstream bit in
    a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && shift_i && !capture_i) |=> (sh_q == $past(scan_i)));

    // R8: no selected capture or shift leaves the shift stage untouched
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && (capture_i || shift_i)) |=> $stable(sh_q));

    // R7: the update stage moves only on a selected update
    a_r7_upd_silent: assert property (@(negedge clk) disable iff (!rst_n)
        !(sel_i && update_i) |=> $stable(upd_q));

    // R9: the update stage clears under reset
    a_r9_upd_clear: assert property (@(negedge clk)
        !rst_n |=> (upd_q == 1'b0));
endmodule

// File: rtl/core_bscan_chain.sv
// Module: boundary register chain around a core's unidirectional terminals.
// Input cells come first on the serial path, then the output cells.
// Assumes a single wrapper clock and controls stable over each cycle.
module core_bscan_chain #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             sel_i,
    input  logic             capture_i,
    input  logic             shift_i,
    input  logic             update_i,
    input  logic             tdi_i,
    output logic             tdo_o,
    input  logic [N_IN-1:0]  chip_in_i,
    output logic [N_IN-1:0]  core_in_o,
    input  logic [N_OUT-1:0] core_out_i,
    output logic [N_OUT-1:0] chip_out_o
);
    localparam int N_CELLS = N_IN + N_OUT;

    logic               drv_in;
    logic               drv_out;
    logic [N_CELLS-1:0] cell_fin;
    logic [N_CELLS-1:0] cell_fout;
    logic [N_CELLS:0]   scan_link;

    bscan_mode_reg u_mode (
        .clk               (clk),
        .rst_n             (rst_n),
        .mode_i            (mode_i),
        .drive_in_cells_o  (drv_in),
        .drive_out_cells_o (drv_out)
    );

    // Gather functional inputs in serial order and split the cell outputs.
    always_comb begin
        cell_fin     = {core_out_i, chip_in_i};
        core_in_o    = cell_fout[N_IN-1:0];
        chip_out_o   = cell_fout[N_CELLS-1:N_IN];
        scan_link[0] = tdi_i;
        tdo_o        = scan_link[N_CELLS];
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        localparam bit IS_OUT = (i >= N_IN);
        logic drive_test;
        assign drive_test = IS_OUT ? drv_out : drv_in;

        bscan_cell u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel_i        (sel_i),
            .capture_i    (capture_i),
            .shift_i      (shift_i),
            .update_i     (update_i),
            .drive_test_i (drive_test),
            .func_i       (cell_fin[i]),
            .scan_i       (scan_link[i]),
            .func_o       (cell_fout[i]),
            .scan_o       (scan_link[i+1])
        );
    end
endmodule

// File: tb/core_bscan_chain_tb_top.sv
`timescale 1ns/1ps
module core_bscan_chain_tb_top;
    localparam int N_IN  = 4;
    localparam int N_OUT = 3;
    localparam int NT    = N_IN + N_OUT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic             sel_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0;
    logic             tdi_i = 1'b0;
    logic             tdo_o;
    logic [N_IN-1:0]  chip_in_i = '0;
    logic [N_IN-1:0]  core_in_o;
    logic [N_OUT-1:0] core_out_i = '0;
    logic [N_OUT-1:0] chip_out_o;

    int checks = 0;
    int errors = 0;

    logic [NT-1:0] m_sh, m_upd;
    logic [1:0]    m_mode;

    always #2 clk = ~clk;

    core_bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sel_i(sel_i),
        .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
        .tdi_i(tdi_i), .tdo_o(tdo_o), .chip_in_i(chip_in_i),
        .core_in_o(core_in_o), .core_out_i(core_out_i), .chip_out_o(chip_out_o)
    );

    function automatic logic [N_IN-1:0] exp_core_in();
        return (m_mode == 2'b01) ? m_upd[N_IN-1:0] : chip_in_i;
    endfunction

    function automatic logic [N_OUT-1:0] exp_chip_out();
        return (m_mode == 2'b10) ? m_upd[NT-1:N_IN] : core_out_i;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive after a rising edge, check after the falling edge.
    task automatic cyc(string tag, bit r, bit s, bit cap, bit sh, bit up,
                       logic [1:0] md, bit di);
        rst_n = r; sel_i = s; capture_i = cap; shift_i = sh; update_i = up;
        mode_i = md; tdi_i = di;
        chip_in_i  = N_IN'($urandom);
        core_out_i = N_OUT'($urandom);
        if (!r)           m_upd = '0;
        else if (s && up) m_upd = m_sh;
        @(negedge clk); #1;
        check(tag, "core_in_o", 32'(core_in_o), 32'(exp_core_in()));
        check(tag, "chip_out_o", 32'(chip_out_o), 32'(exp_chip_out()));
        check(tag, "tdo_o", 32'(tdo_o), 32'(m_sh[NT-1]));
        if (!r) begin
            m_sh = '0; m_mode = 2'b00;
        end else begin
            if (s && cap)     m_sh = {core_out_i, chip_in_i};
            else if (s && sh) m_sh = {m_sh[NT-2:0], di};
            m_mode = md;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NT-1:0] pat;
        void'($urandom(32'd1500));
        repeat (2) @(posedge clk);
        #1;
        m_sh = '0; m_upd = '0; m_mode = 2'b00;
        // R9: reset state, normal pass-through
        for (int k = 0; k < 3; k++) cyc("R9", 0, 1, 1, 1, 1, 2'b01, 1);
        // R10 then R1: the mode change lags one edge, and the serial load begins
        pat = NT'(7'b1011001);
        for (int k = 0; k < NT; k++)
            cyc(k < 2 ? "R10" : "R1", 1, 1, 0, 1, 0, 2'b01, pat[NT-1-k]);
        // R6: parallel update drives the pattern onto the core inputs (R2)
        cyc("R6", 1, 1, 0, 0, 1, 2'b01, 0);
        cyc("R2", 1, 1, 0, 0, 0, 2'b01, 0);
        // R7: shifting leaves the driven outputs frozen; tdo streams the pattern
        for (int k = 0; k < NT; k++) cyc("R7", 1, 1, 0, 1, 0, 2'b01, 1'($urandom));
        // R8: unselected controls have no effect
        for (int k = 0; k < 6; k++) cyc("R8", 1, 0, k[0], 1, 1, 2'b01, 1);
        // R5: capture beats shift, then shift the captured value out
        cyc("R5", 1, 1, 1, 1, 0, 2'b10, 1);
        for (int k = 0; k < NT; k++) cyc("R5", 1, 1, 0, 1, 0, 2'b10, 0);
        // R3: outward-facing update drives the chip outputs
        for (int k = 0; k < NT; k++) cyc("R3", 1, 1, 0, 1, 0, 2'b10, 1'($urandom));
        cyc("R3", 1, 1, 0, 0, 1, 2'b10, 0);
        for (int k = 0; k < 3; k++) cyc("R3", 1, 1, 0, 0, 0, 2'b10, 0);
        // R4: spare and normal codes pass through
        for (int k = 0; k < 4; k++) cyc("R4", 1, 1, 0, 0, 0, 2'(k[0] ? 3 : 0), 0);
        // Random mix; the tag follows the active mode
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] md;
            md = 2'($urandom);
            cyc(m_mode == 2'b01 ? "R2" : (m_mode == 2'b10 ? "R3" : "R4"),
                ($urandom % 50) != 0, ($urandom % 5) != 0, ($urandom % 6) == 0,
                ($urandom % 2) == 0, ($urandom % 4) == 0, md, 1'($urandom));
        end
        // R9: reset mid-run clears everything
        cyc("R9", 0, 1, 0, 0, 0, 2'b01, 0);
        cyc("R9", 0, 1, 0, 0, 0, 2'b01, 0);
        cyc("R9", 1, 1, 0, 0, 0, 2'b01, 0);
        cyc("R9", 1, 1, 0, 0, 0, 2'b01, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule